// File: doc/BRIEF.md
# Page Access Permission Checker

This unit sits at the end of a page-table walk. It receives the effective user, writable and no-execute flags that the walk has combined across all levels. It also receives the leaf entry's dirty and accessed bits, a reserved-bit violation flag from the walk, the kind of access (read, write or instruction fetch), the privilege of the requester, and four control bits:

- supervisor access blocking on user pages
- supervisor write protection
- supervisor execute blocking on user pages
- no-execute enable

From these it decides whether the access may proceed.

The checker works in two steps. First it builds a permission vector of read, write and execute grants. Then it selects the fault by access kind. When the access is allowed, it asks the walker to set the accessed and/or dirty bits in the leaf entry. It reports the grants that may be cached, and write is granted only for a page that is dirty once the access completes. When the access is refused, it produces a page-fault error code.

A single-cycle `req_valid` strobe starts one evaluation. All results are registered and appear together with a one-cycle `done` pulse on the next clock edge. A new request may be issued on every cycle.

Top module: `page_perm_check`

## Requirements
- R1: A user access (`req_user`=1) to a page whose effective user flag is clear always faults, with error-code bit 0 and bit 2 set.
- R2: Read permission is granted unless the access is supervisor, `ctl_sap` is 1 and the page is a user page.
- R3: Write permission requires read permission and either the writable flag set, or a supervisor access with `ctl_wp` clear.
- R4: Execute permission requires `leaf_nx` clear, and for a supervisor access also that `ctl_sep` is 0 or the page is not a user page.
- R5: Access kind is encoded read=0, write=1, fetch=2. The access faults when the permission bit matching its kind is clear. Code 3 always faults. On any fault all grants and leaf update requests are 0.
- R6: When `leaf_rsvd` is 1 the access faults regardless of permissions, with error-code bits 3 and 0 set.
- R7: On a fault the error code (5 bits) has bit 0 set, bit 1 set for a write, bit 2 set for a user access, bit 3 set for a reserved violation, and bit 4 set for a fetch while `ctl_nxe` or `ctl_sep` is 1. Without a fault the error code is 0.
- R8: On an allowed access, `set_dirty` is 1 for a write to a leaf whose dirty bit is clear. `set_acc` is 1 when the accessed bit is clear or `set_dirty` is 1.
- R9: On an allowed access, `allow_w` is reported only when the leaf is dirty or the current access is a write that dirties it. `allow_r` and `allow_x` follow R2 and R4.
- R10: Results appear on the clock edge after `req_valid`, with `done` high for exactly that cycle. Between requests all result outputs hold their last value.
- R11: After reset `done`, all grants, `fault`, `err_code`, `set_acc` and `set_dirty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start one evaluation |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-privilege access |
| leaf_usr | input | 1 | Combined user flag of the walk |
| leaf_wr | input | 1 | Combined writable flag of the walk |
| leaf_nx | input | 1 | Combined no-execute flag (1 = execution barred) |
| leaf_dirty | input | 1 | Leaf entry dirty bit |
| leaf_acc | input | 1 | Leaf entry accessed bit |
| leaf_rsvd | input | 1 | Walk found a reserved-bit violation |
| ctl_sap | input | 1 | Block supervisor data access to user pages |
| ctl_wp | input | 1 | Honour the writable flag for supervisor writes |
| ctl_sep | input | 1 | Block supervisor execution from user pages |
| ctl_nxe | input | 1 | No-execute feature enabled |
| done | output | 1 | One-cycle result strobe |
| allow_r | output | 1 | Read may be cached |
| allow_w | output | 1 | Write may be cached |
| allow_x | output | 1 | Execute may be cached |
| fault | output | 1 | Access refused |
| err_code | output | 5 | Page-fault error code |
| set_acc | output | 1 | Request to set the leaf accessed bit |
| set_dirty | output | 1 | Request to set the leaf dirty bit |

## Verification
Every result of this block is due exactly one clock edge after the request strobe. This holds for the grants, the fault flag, the error code, the leaf update requests and `done`. The driver applies each request on a falling edge and queues the expected result at the same time. The monitor pops and compares on the next falling edge, and only where `done` is high, so each comparison lands half a cycle after the registers update. Idle cycles are inserted between some requests so that the `done` pulse width and the hold of outputs between requests are also exercised.

// File: rtl/page_perm_pkg.sv
package page_perm_pkg;

  localparam int KIND_W = 2;
  localparam int ERR_W  = 5;

  // error-code bit positions
  localparam int EB_PROT  = 0;
  localparam int EB_WRITE = 1;
  localparam int EB_USER  = 2;
  localparam int EB_RSVD  = 3;
  localparam int EB_FETCH = 4;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_BAD   = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_vec_t;

  typedef struct packed {
    logic usr;
    logic wr;
    logic nx;
  } leaf_flags_t;

  typedef struct packed {
    logic sap;
    logic wp;
    logic sep;
    logic nxe;
  } ctl_bits_t;

  function automatic logic fn_read_ok(input logic user_acc, input leaf_flags_t f,
                                      input ctl_bits_t c);
    return !(c.sap && !user_acc && f.usr);
  endfunction

  function automatic logic fn_write_ok(input logic rd_ok, input logic user_acc,
                                       input leaf_flags_t f, input ctl_bits_t c);
    return rd_ok && (f.wr || (!user_acc && !c.wp));
  endfunction

  function automatic logic fn_exec_ok(input logic user_acc, input leaf_flags_t f,
                                      input ctl_bits_t c);
    return !f.nx && (user_acc || !(c.sep && f.usr));
  endfunction

  function automatic logic fn_kind_allowed(input acc_kind_e k, input perm_vec_t p);
    logic ok;
    case (k)
      KIND_READ:  ok = p.r;
      KIND_WRITE: ok = p.w;
      KIND_FETCH: ok = p.x;
      default:    ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic [ERR_W-1:0] fn_err_code(input logic flt, input logic rsvd,
                                                   input acc_kind_e k, input logic user_acc,
                                                   input ctl_bits_t c);
    logic [ERR_W-1:0] e;
    e = '0;
    if (flt) begin
      e[EB_PROT]  = 1'b1;
      e[EB_WRITE] = (k == KIND_WRITE);
      e[EB_USER]  = user_acc;
      e[EB_RSVD]  = rsvd;
      e[EB_FETCH] = (k == KIND_FETCH) && (c.nxe || c.sep);
    end
    return e;
  endfunction

endpackage

// File: rtl/page_perm_vec.sv
module page_perm_vec
  import page_perm_pkg::*;
(
  input  logic        user_acc,
  input  leaf_flags_t flags,
  input  ctl_bits_t   ctl,
  output perm_vec_t   perm
);

  logic rd_ok;
  logic wr_ok;
  logic ex_ok;

  always_comb begin
    rd_ok = fn_read_ok(user_acc, flags, ctl);
    wr_ok = fn_write_ok(rd_ok, user_acc, flags, ctl);
    ex_ok = fn_exec_ok(user_acc, flags, ctl);
    perm  = '{r: rd_ok, w: wr_ok, x: ex_ok};
  end

endmodule

// File: rtl/page_fault_sel.sv
module page_fault_sel
  import page_perm_pkg::*;
(
  input  acc_kind_e        kind,
  input  logic             user_acc,
  input  logic             page_usr,
  input  logic             rsvd,
  input  ctl_bits_t        ctl,
  input  perm_vec_t        perm,
  output logic             user_viol,
  output logic             kind_denied,
  output logic             flt,
  output logic [ERR_W-1:0] err
);

  always_comb begin
    user_viol   = user_acc && !page_usr;
    kind_denied = !fn_kind_allowed(kind, perm);
    flt         = rsvd || user_viol || kind_denied;
    err         = fn_err_code(flt, rsvd, kind, user_acc, ctl);
  end

endmodule

// File: rtl/page_leaf_update.sv
module page_leaf_update
  import page_perm_pkg::*;
(
  input  acc_kind_e kind,
  input  logic      flt,
  input  logic      dirty_in,
  input  logic      acc_in,
  input  perm_vec_t perm,
  output logic      mark_dirty,
  output logic      mark_acc,
  output perm_vec_t granted
);

  logic dirty_after;

  always_comb begin
    mark_dirty  = !flt && (kind == KIND_WRITE) && !dirty_in;
    mark_acc    = !flt && (!acc_in || mark_dirty);
    dirty_after = dirty_in || mark_dirty;
    if (flt) begin
      granted = '0;
    end else begin
      granted   = perm;
      granted.w = perm.w && dirty_after;
    end
  end

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
  import page_perm_pkg::*;
#(
  parameter int EW = ERR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic          req_user,
  input  logic          leaf_usr,
  input  logic          leaf_wr,
  input  logic          leaf_nx,
  input  logic          leaf_dirty,
  input  logic          leaf_acc,
  input  logic          leaf_rsvd,
  input  logic          ctl_sap,
  input  logic          ctl_wp,
  input  logic          ctl_sep,
  input  logic          ctl_nxe,
  output logic          done,
  output logic          allow_r,
  output logic          allow_w,
  output logic          allow_x,
  output logic          fault,
  output logic [EW-1:0] err_code,
  output logic          set_acc,
  output logic          set_dirty
);

  leaf_flags_t      flags_w;
  ctl_bits_t        ctl_w;
  acc_kind_e        kind_w;
  perm_vec_t        perm_w;
  perm_vec_t        grant_w;
  logic             user_viol_w;
  logic             kind_denied_w;
  logic             flt_w;
  logic [ERR_W-1:0] err_w;
  logic             mark_d_w;
  logic             mark_a_w;

  always_comb begin
    flags_w = '{usr: leaf_usr, wr: leaf_wr, nx: leaf_nx};
    ctl_w   = '{sap: ctl_sap, wp: ctl_wp, sep: ctl_sep, nxe: ctl_nxe};
    kind_w  = acc_kind_e'(req_kind);
  end

  page_perm_vec u_vec (
    .user_acc (req_user),
    .flags    (flags_w),
    .ctl      (ctl_w),
    .perm     (perm_w)
  );

  page_fault_sel u_sel (
    .kind        (kind_w),
    .user_acc    (req_user),
    .page_usr    (leaf_usr),
    .rsvd        (leaf_rsvd),
    .ctl         (ctl_w),
    .perm        (perm_w),
    .user_viol   (user_viol_w),
    .kind_denied (kind_denied_w),
    .flt         (flt_w),
    .err         (err_w)
  );

  page_leaf_update u_upd (
    .kind       (kind_w),
    .flt        (flt_w),
    .dirty_in   (leaf_dirty),
    .acc_in     (leaf_acc),
    .perm       (perm_w),
    .mark_dirty (mark_d_w),
    .mark_acc   (mark_a_w),
    .granted    (grant_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done      <= 1'b0;
      allow_r   <= 1'b0;
      allow_w   <= 1'b0;
      allow_x   <= 1'b0;
      fault     <= 1'b0;
      err_code  <= '0;
      set_acc   <= 1'b0;
      set_dirty <= 1'b0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        allow_r   <= grant_w.r;
        allow_w   <= grant_w.w;
        allow_x   <= grant_w.x;
        fault     <= flt_w;
        err_code  <= EW'(err_w);
        set_acc   <= mark_a_w;
        set_dirty <= mark_d_w;
      end
    end
  end

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done); // R10
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done); // R10
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(fault) && $stable(err_code) && $stable(allow_w))); // R10
  AST_USER_PAGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_user && !leaf_usr) |=> (fault && err_code[EB_USER] && err_code[EB_PROT])); // R1
  AST_RSVD_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && leaf_rsvd) |=> (fault && err_code[EB_RSVD])); // R6
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    allow_w |-> allow_r); // R3
  AST_FAULT_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(allow_r || allow_w || allow_x || set_acc || set_dirty)); // R5
  AST_FAULT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> err_code[EB_PROT]); // R7
  AST_CLEAN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    !fault |-> (err_code == '0)); // R7
  AST_DIRTY_WITH_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |-> set_acc); // R8

endmodule

// File: tb/page_perm_check_test.sv
module page_perm_check_test;

  typedef struct packed {
    logic       r;
    logic       w;
    logic       x;
    logic       flt;
    logic [4:0] err;
    logic       sa;
    logic       sd;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic       req_user = 1'b0;
  logic       leaf_usr = 1'b0, leaf_wr = 1'b0, leaf_nx = 1'b0;
  logic       leaf_dirty = 1'b0, leaf_acc = 1'b0, leaf_rsvd = 1'b0;
  logic       ctl_sap = 1'b0, ctl_wp = 1'b0, ctl_sep = 1'b0, ctl_nxe = 1'b0;
  logic       done, allow_r, allow_w, allow_x, fault, set_acc, set_dirty;
  logic [4:0] err_code;

  int   errors = 0;
  int   checks = 0;
  bit   finished = 1'b0;
  exp_t sb_q[$];
  exp_t last_exp;

  always #2.5 clk = ~clk;

  page_perm_check uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_user(req_user), .leaf_usr(leaf_usr), .leaf_wr(leaf_wr), .leaf_nx(leaf_nx),
    .leaf_dirty(leaf_dirty), .leaf_acc(leaf_acc), .leaf_rsvd(leaf_rsvd),
    .ctl_sap(ctl_sap), .ctl_wp(ctl_wp), .ctl_sep(ctl_sep), .ctl_nxe(ctl_nxe),
    .done(done), .allow_r(allow_r), .allow_w(allow_w), .allow_x(allow_x),
    .fault(fault), .err_code(err_code), .set_acc(set_acc), .set_dirty(set_dirty)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model, phrased from the requirement text
  function automatic exp_t model(input logic [12:0] v);
    logic [1:0] kind;
    logic usr_acc, u, rw, nx, d, a, rsv, sap, wp, sep, nxe;
    logic may_r, may_w, may_x, deny;
    exp_t e;
    {kind, usr_acc, u, rw, nx, d, a, rsv, sap, wp, sep, nxe} = v;
    may_r = usr_acc | ~sap | ~u;                       // R2
    may_w = may_r & (rw | (~usr_acc & ~wp));           // R3
    may_x = ~nx & (usr_acc | ~sep | ~u);               // R4
    deny  = rsv | (usr_acc & ~u);                      // R1 R6
    if (kind == 2'd0) deny |= ~may_r;                  // R5
    else if (kind == 2'd1) deny |= ~may_w;
    else if (kind == 2'd2) deny |= ~may_x;
    else deny = 1'b1;
    e = '0;
    e.flt = deny;
    if (deny) begin
      e.err = {(kind == 2'd2) & (nxe | sep), rsv, usr_acc, kind == 2'd1, 1'b1}; // R7
    end else begin
      e.sd = (kind == 2'd1) & ~d;                      // R8
      e.sa = ~a | e.sd;
      e.r  = may_r;
      e.w  = may_w & (d | (kind == 2'd1));             // R9
      e.x  = may_x;
    end
    return e;
  endfunction

  task automatic drive(input logic [12:0] v);
    @(negedge clk);
    {req_kind, req_user, leaf_usr, leaf_wr, leaf_nx, leaf_dirty, leaf_acc,
     leaf_rsvd, ctl_sap, ctl_wp, ctl_sep, ctl_nxe} = v;
    req_valid = 1'b1;
    sb_q.push_back(model(v));
    last_exp = model(v);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: pops one expected item per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) begin
        check("R10 done without request", 8'd1, 8'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check("R2/R3/R4/R9 grants", {5'd0, allow_r, allow_w, allow_x}, {5'd0, e.r, e.w, e.x});
        check("R1/R5/R6 fault", {7'd0, fault}, {7'd0, e.flt});
        check("R7 err_code", {3'd0, err_code}, {3'd0, e.err});
        check("R8 leaf update", {6'd0, set_acc, set_dirty}, {6'd0, e.sa, e.sd});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 reset outputs",
          {done, allow_r, allow_w, allow_x, fault, set_acc, set_dirty, |err_code}, 8'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 8192; i++) begin
      drive(13'(i));
      if (i % 7 == 3) idle();
    end
    idle();
    @(negedge clk);
    // R10: done is a single pulse, results hold between requests
    check("R10 done low when idle", {7'd0, done}, 8'd0);
    check("R10 held err_code", {3'd0, err_code}, {3'd0, last_exp.err});
    check("R10 held fault", {7'd0, fault}, {7'd0, last_exp.flt});
    check("R10 queue drained", 8'(sb_q.size()), 8'd0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule